// File: doc/BRIEF.md
# Exception entry and return sequencer

This block carries out the memory side of taking an exception and of returning from one, for a 32-bit core. On an exception or an accepted interrupt it captures the core's program counter, status word, supervisor stack pointer and vector base. It then stores a two-longword frame on the supervisor stack and reads the handler address from the vector table. It finishes with a one-cycle completion pulse. At that pulse it hands back the new program counter, the new stack pointer and the new status word, each with a load strobe. The core owns the stack-pointer bank and the status register, and applies the strobed values.

The frame has two longwords. One holds the return address. The other is a packed word: a fixed two-bit tag, the two low bits the stack pointer had before alignment, the vector offset and the full 16-bit status word. On return the block reads both words back. It rebuilds the stack pointer, including its original low bits, and restores the status word. A small comparator decides whether a pending hardware interrupt level may be taken at all.

Memory traffic goes through one 32-bit master port. That port has a valid/ready handshake, with at most one access outstanding. The block is busy from the cycle after a request is accepted until its completion pulse.

Top module: `exc_seq`

## Requirements
- R1: After reset, busy, done, mem_valid, sp_load and sr_load are all low.
- R2: irq_accept is high exactly when irq_level is strictly greater than the 3-bit interrupt mask held in cur_sr bits 10:8.
- R3: On entry the stack pointer ssp is aligned down to a multiple of 4 (call it A). The return address is written to A-4. The return address is cur_pc+2 for vector numbers 32 to 47 inclusive, and cur_pc for every other vector.
- R4: On entry the packed word is written to A-8. Bits 31:30 are 01. Bits 29:28 are ssp bits 1:0. Bits 27:16 are the vector number times 4. Bits 15:0 are cur_sr as it was before the exception.
- R5: On entry the handler address is read from vbr + 4 × vector. done pulses for exactly one cycle, and new_pc then equals the longword read.
- R6: At done after entry, sp_load is high and sp_next equals A-8. sp_load and sr_load are never high outside done.
- R7: At done after entry, sr_load is high and sr_next equals cur_sr with bit 13 (supervisor) set. For a hardware interrupt, bits 10:8 are also set to irq_level and bit 12 is cleared.
- R8: A hardware request (req_hw=1) whose level is not accepted under R2 is ignored. busy stays low and no memory access is made.
- R9: On return (rte_req) the block reads the packed word at ssp and the PC at ssp+4. At done, new_pc is the PC read and sp_next is (ssp+8) OR packed bits 29:28. sr_next is packed bits 15:0, and both load strobes are high.
- R10: When an accepted exception request and rte_req arrive in the same idle cycle, the exception is taken and the return request is dropped.
- R11: mem_valid is high only while busy. Once raised, it holds with the same address and direction until mem_ready is seen.
- R12: Requests arriving while busy are ignored. A sequence stays busy until its done cycle and makes no accesses beyond its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception or interrupt request, sampled when idle |
| req_vector | input | VEC_W | Vector number of the request |
| req_hw | input | 1 | Request is a hardware interrupt |
| irq_level | input | 3 | Level of the pending hardware interrupt |
| rte_req | input | 1 | Return-from-exception request |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 16 | Current status word |
| ssp | input | 32 | Supervisor stack pointer |
| vbr | input | 32 | Vector table base |
| irq_accept | output | 1 | Pending interrupt level exceeds the mask |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 32 | Program counter to load at done |
| sp_load | output | 1 | Load strobe for sp_next |
| sp_next | output | 32 | New supervisor stack pointer |
| sr_load | output | 1 | Load strobe for sr_next |
| sr_next | output | 16 | New status word |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | Access is a write |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready on reads |

## Verification
An exception request and a return request can both land in the same idle cycle. The same clash can be provoked by a hardware request that falls at or below the mask, so that the return must proceed instead. The bench raises req_valid and rte_req together from one driving edge. It judges the result from the memory traffic and the strobed values: a taken exception shows frame writes below the aligned stack pointer and the handler address as new_pc. A taken return instead shows two reads at ssp and ssp+4. A second clash source is a request that arrives in the middle of a running sequence. The bench checks this one by counting the accesses, which must be exactly those of the sequence already running.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN      = 32;
  localparam int SRW       = 16;
  localparam int LVLW      = 3;
  localparam int VOFFW     = 10;     // vector field width inside the packed word
  localparam int SR_S_BIT  = 13;
  localparam int SR_M_BIT  = 12;
  localparam int SR_I_LO   = 8;
  localparam int TRAP_LO   = 32;
  localparam int TRAP_HI   = 47;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_PC, ST_PUSH_FMT, ST_FETCH, ST_POP_FMT, ST_POP_PC, ST_FIN
  } seq_state_t;

  function automatic logic [XLEN-1:0] align_down4(input logic [XLEN-1:0] sp);
    return {sp[XLEN-1:2], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] vec_offset(input logic [VOFFW-1:0] vec);
    return {{(XLEN-VOFFW-2){1'b0}}, vec, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] pack_frame(input logic [1:0] sp_lo,
                                                 input logic [VOFFW-1:0] vec,
                                                 input logic [SRW-1:0] sr);
    return {2'b01, sp_lo, vec, 2'b00, sr};
  endfunction

  function automatic logic [XLEN-1:0] return_addr(input logic [XLEN-1:0] pc,
                                                  input logic [VOFFW-1:0] vec);
    if (int'(vec) >= TRAP_LO && int'(vec) <= TRAP_HI) return pc + 32'd2;
    return pc;
  endfunction

  function automatic logic [SRW-1:0] entry_status(input logic [SRW-1:0] sr,
                                                  input logic hw,
                                                  input logic [LVLW-1:0] lvl);
    logic [SRW-1:0] s;
    s = sr;
    s[SR_S_BIT] = 1'b1;
    if (hw) begin
      s[SR_I_LO +: LVLW] = lvl;
      s[SR_M_BIT] = 1'b0;
    end
    return s;
  endfunction

  function automatic logic [XLEN-1:0] unwind_sp(input logic [XLEN-1:0] sp,
                                                input logic [XLEN-1:0] fmt);
    return (sp + 32'd8) | {{(XLEN-2){1'b0}}, fmt[29:28]};
  endfunction

  function automatic logic [SRW-1:0] unwind_sr(input logic [XLEN-1:0] fmt);
    return fmt[SRW-1:0];
  endfunction
endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate
  import exc_pkg::*;
(
  input  logic [LVLW-1:0] mask,
  input  logic [LVLW-1:0] level,
  output logic            accept
);
  assign accept = (level > mask);
endmodule

// File: rtl/exc_frame_calc.sv
module exc_frame_calc
  import exc_pkg::*;
(
  input  logic [XLEN-1:0]  ctx_pc,
  input  logic [SRW-1:0]   ctx_sr,
  input  logic [XLEN-1:0]  ctx_ssp,
  input  logic [XLEN-1:0]  ctx_vbr,
  input  logic [VOFFW-1:0] ctx_vec,
  input  logic             ctx_hw,
  input  logic [LVLW-1:0]  ctx_lvl,
  input  logic [XLEN-1:0]  fmt_rd,
  output logic [XLEN-1:0]  a_pc,
  output logic [XLEN-1:0]  d_pc,
  output logic [XLEN-1:0]  a_fmt,
  output logic [XLEN-1:0]  d_fmt,
  output logic [XLEN-1:0]  a_vec,
  output logic [XLEN-1:0]  a_rfmt,
  output logic [XLEN-1:0]  a_rpc,
  output logic [XLEN-1:0]  ent_sp,
  output logic [SRW-1:0]   ent_sr,
  output logic [XLEN-1:0]  ret_sp,
  output logic [SRW-1:0]   ret_sr
);
  logic [XLEN-1:0] base;

  assign base   = align_down4(ctx_ssp);
  assign a_pc   = base - 32'd4;
  assign d_pc   = return_addr(ctx_pc, ctx_vec);
  assign a_fmt  = base - 32'd8;
  assign d_fmt  = pack_frame(ctx_ssp[1:0], ctx_vec, ctx_sr);
  assign a_vec  = ctx_vbr + vec_offset(ctx_vec);
  assign a_rfmt = ctx_ssp;
  assign a_rpc  = ctx_ssp + 32'd4;
  assign ent_sp = a_fmt;
  assign ent_sr = entry_status(ctx_sr, ctx_hw, ctx_lvl);
  assign ret_sp = unwind_sp(ctx_ssp, fmt_rd);
  assign ret_sr = unwind_sr(fmt_rd);
endmodule

// File: rtl/exc_seq_ctl.sv
module exc_seq_ctl
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_entry,
  input  logic            start_ret,
  input  logic [XLEN-1:0] a_pc,
  input  logic [XLEN-1:0] d_pc,
  input  logic [XLEN-1:0] a_fmt,
  input  logic [XLEN-1:0] d_fmt,
  input  logic [XLEN-1:0] a_vec,
  input  logic [XLEN-1:0] a_rfmt,
  input  logic [XLEN-1:0] a_rpc,
  input  logic            mem_ready,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            busy,
  output logic            done,
  output logic            is_entry,
  output logic [XLEN-1:0] pc_rd,
  output logic [XLEN-1:0] fmt_rd
);
  seq_state_t state_q, state_d;
  logic       xfer;

  always_comb begin
    mem_valid = 1'b1;
    mem_write = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state_q)
      ST_PUSH_PC:  begin mem_write = 1'b1; mem_addr = a_pc;  mem_wdata = d_pc;  end
      ST_PUSH_FMT: begin mem_write = 1'b1; mem_addr = a_fmt; mem_wdata = d_fmt; end
      ST_FETCH:    mem_addr = a_vec;
      ST_POP_FMT:  mem_addr = a_rfmt;
      ST_POP_PC:   mem_addr = a_rpc;
      default:     mem_valid = 1'b0;
    endcase
  end

  assign xfer = mem_valid & mem_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (start_entry)    state_d = ST_PUSH_PC;
        else if (start_ret) state_d = ST_POP_FMT;
      end
      ST_PUSH_PC:  if (xfer) state_d = ST_PUSH_FMT;
      ST_PUSH_FMT: if (xfer) state_d = ST_FETCH;
      ST_FETCH:    if (xfer) state_d = ST_FIN;
      ST_POP_FMT:  if (xfer) state_d = ST_POP_PC;
      ST_POP_PC:   if (xfer) state_d = ST_FIN;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      is_entry <= 1'b0;
      pc_rd    <= '0;
      fmt_rd   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && (start_entry || start_ret)) is_entry <= start_entry;
      if (xfer && (state_q == ST_FETCH || state_q == ST_POP_PC)) pc_rd <= mem_rdata;
      if (xfer && state_q == ST_POP_FMT) fmt_rd <= mem_rdata;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_FIN);
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VEC_W-1:0]  req_vector,
  input  logic              req_hw,
  input  logic [LVLW-1:0]   irq_level,
  input  logic              rte_req,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [SRW-1:0]    cur_sr,
  input  logic [XLEN-1:0]   ssp,
  input  logic [XLEN-1:0]   vbr,
  output logic              irq_accept,
  output logic              busy,
  output logic              done,
  output logic [XLEN-1:0]   new_pc,
  output logic              sp_load,
  output logic [XLEN-1:0]   sp_next,
  output logic              sr_load,
  output logic [SRW-1:0]    sr_next,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic              mem_ready,
  input  logic [XLEN-1:0]   mem_rdata
);
  localparam int VEC_EXT = VOFFW;

  logic [XLEN-1:0]    ctx_pc, ctx_ssp, ctx_vbr;
  logic [SRW-1:0]     ctx_sr;
  logic [VEC_EXT-1:0] ctx_vec;
  logic               ctx_hw;
  logic [LVLW-1:0]    ctx_lvl;

  logic take_exc, start_entry, start_ret, is_entry, entry_run;
  logic [XLEN-1:0] a_pc, d_pc, a_fmt, d_fmt, a_vec, a_rfmt, a_rpc;
  logic [XLEN-1:0] ent_sp, ret_sp, pc_rd, fmt_rd;
  logic [SRW-1:0]  ent_sr, ret_sr;

  exc_irq_gate u_gate (
    .mask   (cur_sr[SR_I_LO +: LVLW]),
    .level  (irq_level),
    .accept (irq_accept)
  );

  assign take_exc    = req_valid & (~req_hw | irq_accept);
  assign start_entry = ~busy & take_exc;
  assign start_ret   = ~busy & rte_req & ~take_exc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_pc  <= '0;
      ctx_sr  <= '0;
      ctx_ssp <= '0;
      ctx_vbr <= '0;
      ctx_vec <= '0;
      ctx_hw  <= 1'b0;
      ctx_lvl <= '0;
    end else if (start_entry || start_ret) begin
      ctx_pc  <= cur_pc;
      ctx_sr  <= cur_sr;
      ctx_ssp <= ssp;
      ctx_vbr <= vbr;
      ctx_vec <= VEC_EXT'(req_vector);
      ctx_hw  <= req_hw;
      ctx_lvl <= irq_level;
    end
  end

  exc_frame_calc u_calc (
    .ctx_pc (ctx_pc),  .ctx_sr (ctx_sr),  .ctx_ssp(ctx_ssp), .ctx_vbr(ctx_vbr),
    .ctx_vec(ctx_vec), .ctx_hw (ctx_hw),  .ctx_lvl(ctx_lvl), .fmt_rd (fmt_rd),
    .a_pc   (a_pc),    .d_pc   (d_pc),    .a_fmt  (a_fmt),   .d_fmt  (d_fmt),
    .a_vec  (a_vec),   .a_rfmt (a_rfmt),  .a_rpc  (a_rpc),
    .ent_sp (ent_sp),  .ent_sr (ent_sr),  .ret_sp (ret_sp),  .ret_sr (ret_sr)
  );

  exc_seq_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_entry(start_entry),
    .start_ret  (start_ret),
    .a_pc       (a_pc),
    .d_pc       (d_pc),
    .a_fmt      (a_fmt),
    .d_fmt      (d_fmt),
    .a_vec      (a_vec),
    .a_rfmt     (a_rfmt),
    .a_rpc      (a_rpc),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .mem_valid  (mem_valid),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .busy       (busy),
    .done       (done),
    .is_entry   (is_entry),
    .pc_rd      (pc_rd),
    .fmt_rd     (fmt_rd)
  );

  assign entry_run = busy & is_entry;
  assign new_pc    = pc_rd;
  assign sp_load   = done;
  assign sr_load   = done;
  assign sp_next   = is_entry ? ent_sp : ret_sp;
  assign sr_next   = is_entry ? ent_sr : ret_sr;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic        mem_write,
  input logic        sp_load,
  input logic        sr_load,
  input logic [15:0] sr_next,
  input logic        entry_run,
  input logic        req_valid,
  input logic        req_hw,
  input logic        irq_accept,
  input logic        rte_req
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)); // R11
  AST_BUS_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R5
  AST_LOAD_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_load || sr_load) |-> done); // R6
  AST_SUPER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load && entry_run |-> sr_next[13]); // R7
  AST_LOW_IRQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_valid && req_hw && !irq_accept && !rte_req |=> !busy); // R8
  AST_EXC_OVER_RTE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_valid && !req_hw |=> busy && entry_run); // R10
  AST_BUSY_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy); // R12
endmodule

bind exc_seq exc_seq_chk u_chk (.*);

// File: tb/test_exc_seq.sv
`timescale 1ns/1ps
module test_exc_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_vector = '0;
  logic        req_hw = 1'b0;
  logic [2:0]  irq_level = '0;
  logic        rte_req = 1'b0;
  logic [31:0] cur_pc = '0;
  logic [15:0] cur_sr = '0;
  logic [31:0] ssp = '0;
  logic [31:0] vbr = '0;
  logic        irq_accept, busy, done, sp_load, sr_load, mem_valid, mem_write;
  logic [31:0] new_pc, sp_next, mem_addr, mem_wdata;
  logic [15:0] sr_next;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  int n_acc = 0;
  logic [31:0] mem [logic [31:0]];

  exc_seq i_exc_seq (.*);

  always #2 clk = ~clk;

  // memory responder: decides ready at the falling edge, transfer at the next rising edge
  always @(negedge clk) begin
    mem_ready = 1'b0;
    if (rst_n && mem_valid && ($urandom % 4 != 0)) begin
      mem_ready = 1'b1;
      n_acc++;
      if (mem_write) mem[mem_addr] = mem_wdata;
      else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'hDEAD_BEEF;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  function automatic logic [31:0] x_ret(input logic [7:0] v, input logic [31:0] pc);
    return (v >= 8'd32 && v <= 8'd47) ? pc + 2 : pc;
  endfunction
  function automatic logic [31:0] x_fmt(input logic [7:0] v, input logic [31:0] sp, input logic [15:0] sr);
    return 32'h4000_0000 + ((sp % 4) << 28) + ((32'(v) * 4) << 16) + 32'(sr);
  endfunction
  function automatic logic [15:0] x_sr(input logic [15:0] sr, input bit hw, input logic [2:0] l);
    if (hw) return (sr & 16'hE8FF) | 16'h2000 | (16'(l) << 8);
    return sr | 16'h2000;
  endfunction

  task automatic do_return(input logic [31:0] sp, input logic [31:0] epc,
                           input logic [31:0] esp, input logic [15:0] esr);
    bit ok;
    int a0;
    @(negedge clk);
    ssp = sp; rte_req = 1'b1; a0 = n_acc;
    @(negedge clk);
    rte_req = 1'b0;
    wait_done(ok);
    chk(ok, "R9 return done", 32'(ok), 1);
    chk(new_pc == epc, "R9 return pc", new_pc, epc);
    chk(sp_load && sp_next == esp, "R9 return sp", sp_next, esp);
    chk(sr_load && sr_next == esr, "R9 return sr", 32'(sr_next), 32'(esr));
    chk(n_acc - a0 == 2, "R9 return reads", n_acc - a0, 2);
  endtask

  task automatic do_entry(input logic [7:0] v, input bit hw, input logic [2:0] l,
                          input logic [31:0] pc, input logic [15:0] sr,
                          input logic [31:0] sp, input logic [31:0] vb,
                          input bit with_rte, input bit mid_rte);
    bit ok;
    int a0;
    logic [31:0] hnd, al, ert;
    hnd = $urandom;
    mem[vb + 32'(v) * 4] = hnd;
    al  = sp - (sp % 4);
    ert = x_ret(v, pc);
    @(negedge clk);
    req_valid = 1'b1; req_vector = v; req_hw = hw; irq_level = l;
    cur_pc = pc; cur_sr = sr; ssp = sp; vbr = vb; rte_req = with_rte;
    a0 = n_acc;
    @(negedge clk);
    req_valid = 1'b0; rte_req = 1'b0;
    if (mid_rte) begin
      @(negedge clk);
      rte_req = 1'b1; req_valid = 1'b1; req_hw = 1'b0;
      @(negedge clk);
      rte_req = 1'b0; req_valid = 1'b0;
    end
    wait_done(ok);
    chk(ok, "R5 entry done", 32'(ok), 1);
    chk(new_pc == hnd, "R5 handler", new_pc, hnd);
    chk(mem.exists(al - 4) && mem[al - 4] == ert, "R3 return addr", mem[al - 4], ert);
    chk(mem.exists(al - 8) && mem[al - 8] == x_fmt(v, sp, sr), "R4 packed word", mem[al - 8], x_fmt(v, sp, sr));
    chk(sp_load && sp_next == al - 8, "R6 entry sp", sp_next, al - 8);
    chk(sr_load && sr_next == x_sr(sr, hw, l), "R7 entry sr", 32'(sr_next), 32'(x_sr(sr, hw, l)));
    if (with_rte) chk(n_acc - a0 == 3, "R10 exception wins", n_acc - a0, 3);
    if (mid_rte) begin
      repeat (4) @(negedge clk);
      chk(!busy && n_acc - a0 == 3, "R12 busy ignores", n_acc - a0, 3);
    end
    do_return(al - 8, ert, sp, sr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_valid && !sp_load && !sr_load, "R1 reset", {busy, done, mem_valid, sp_load, sr_load}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 accept comparator sweep
    for (int m = 0; m < 8; m++) begin
      for (int l = 0; l < 8; l++) begin
        cur_sr = 16'(m << 8) | 16'h2715 & 16'hF8FF;
        irq_level = 3'(l);
        #1;
        chk(irq_accept == (l > m), "R2 accept", 32'(irq_accept), 32'(l > m));
      end
    end

    // directed corners
    do_entry(8'd32, 0, 0, 32'h0000_1000, 16'h0004, 32'h2000_0100, 32'h1000_0000, 0, 0);
    do_entry(8'd47, 0, 0, 32'h0000_2002, 16'h0700, 32'h2000_0203, 32'h1000_0000, 0, 0);
    do_entry(8'd31, 0, 0, 32'h0000_3000, 16'h0000, 32'h2000_0301, 32'h1000_4000, 0, 0);
    do_entry(8'd48, 0, 0, 32'h0000_4000, 16'hFFFF, 32'h2000_0402, 32'h1000_8000, 0, 0);
    do_entry(8'd255, 1, 3'd7, 32'h0000_5000, 16'h1600, 32'h2000_0500, 32'h1000_0000, 0, 0);
    do_entry(8'd64, 0, 0, 32'h0000_6000, 16'h0010, 32'h2000_0600, 32'h1000_0000, 1, 0);
    do_entry(8'd5, 0, 0, 32'h0000_7000, 16'h2000, 32'h2000_0700, 32'h1000_0000, 0, 1);

    // R8 low-level interrupt ignored
    begin
      int a0;
      @(negedge clk);
      cur_sr = 16'h0500; irq_level = 3'd5; req_hw = 1'b1; req_valid = 1'b1; a0 = n_acc;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (5) @(negedge clk);
      chk(!busy && n_acc == a0, "R8 low level ignored", n_acc - a0, 0);
    end

    // R10 companion: rejected hardware request lets the return through
    do_return_pair: begin
      bit ok;
      int a0;
      mem[32'h2000_0800] = 32'h4000_0123;
      mem[32'h2000_0804] = 32'h0000_ABCC;
      @(negedge clk);
      cur_sr = 16'h0700; irq_level = 3'd2; req_hw = 1'b1; req_valid = 1'b1;
      rte_req = 1'b1; ssp = 32'h2000_0800; a0 = n_acc;
      @(negedge clk);
      req_valid = 1'b0; rte_req = 1'b0;
      wait_done(ok);
      chk(ok && new_pc == 32'h0000_ABCC, "R10 rejected irq, return taken", new_pc, 32'h0000_ABCC);
      chk(sp_next == 32'h2000_0808 && sr_next == 16'h0123, "R9 sp bits restored", sp_next, 32'h2000_0808);
    end

    // constrained random round trips
    for (int k = 0; k < 40; k++) begin
      logic [7:0] v; bit hw; logic [2:0] l, m; logic [15:0] sr;
      v  = 8'($urandom);
      hw = $urandom % 2;
      l  = 3'(1 + $urandom % 7);
      m  = 3'($urandom % l);
      sr = 16'($urandom);
      if (hw) sr = (sr & 16'hF8FF) | 16'(m << 8);
      do_entry(v, hw, l, {$urandom} & 32'hFFFF_FFFE, sr,
               32'h2000_0000 + ($urandom % 32'h1_0000) + 32'h10,
               32'h1000_0000 + (($urandom % 16) << 12), 0, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule